// File: doc/BRIEF.md
# While-less-than predicate generator

This block builds a vector predicate from two scalar operands. Element `e` of the vector is compared as the value `A + e` against `B`. The vector length is fixed when the block is built. Element 0 is always the lowest. An element is active while every compare up to and including its own has passed. The first failing compare turns off that element and every element above it. The offset added for each element is exactly one, whatever the element size.

The predicate has one bit per byte of the vector. An element of `k` bytes owns `k` adjacent predicate bits. Only the lowest of those bits carries the element's result. Alongside the predicate the block returns four condition flags:
- N: the first element's result.
- Z: set when no element is active.
- C: the inverse of the last element's result.
- V: always zero.

A caller presents the operands together with a one-cycle `in_valid` strobe. The registered result appears one clock later. The compare can be signed or unsigned, and less-than or less-than-or-equal. The operands are either 32 or 64 bits wide.

Top module: `whl_pred_gen`

## Requirements
- R1: `esize_sel` selects the element size: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. For a size of `k` bytes there are `VL_BITS/(8*k)` elements. Element `e` owns predicate bits `e*k` to `e*k+k-1`. Its result is placed in bit `e*k` and the other bits it owns are 0.
- R2: With `wide_sel`=0 only bits 31:0 of each operand take part and bits 63:32 are ignored. With `wide_sel`=1 all 64 bits take part.
- R3: The value compared for element `e` is `(A + e) mod 2^W`, where W is 32 or 64 as chosen by `wide_sel`. The step is one per element for every element size.
- R4: `unsigned_sel`=0 compares the two values as two's-complement numbers and `unsigned_sel`=1 compares them as unsigned numbers. `le_sel`=0 tests less-than and `le_sel`=1 tests less-than-or-equal.
- R5: Once any element fails its compare, all higher elements are 0. This holds even when a wrapped value would pass the compare again.
- R6: `flag_n` equals the result of element 0.
- R7: `flag_z` is 1 exactly when no element is active.
- R8: `flag_c` is the inverse of the result of the highest element for the selected size.
- R9: `flag_v` is always 0.
- R10: The outputs `pred` and the four flags update on the clock edge that samples `in_valid`=1. `out_valid` is 1 for exactly the cycle after each strobe. Between strobes the outputs hold their values.
- R11: While reset is asserted, `out_valid`, `pred` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures a new result |
| op_a | input | 64 | Start value of the incrementing operand |
| op_b | input | 64 | Limit operand |
| esize_sel | input | 2 | Element size code |
| wide_sel | input | 1 | 0: 32-bit operands, 1: 64-bit operands |
| le_sel | input | 1 | 0: less-than, 1: less-than-or-equal |
| unsigned_sel | input | 1 | 0: signed, 1: unsigned |
| out_valid | output | 1 | High in the cycle after a strobe |
| pred | output | VL_BITS/8 | Predicate, one bit per byte |
| flag_n | output | 1 | First element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Last element inactive |
| flag_v | output | 1 | Always 0 |

## Verification
The bench builds the block with `VL_BITS`=256 and the default log-depth prefix. That length gives 32, 16, 8 and 4 elements for the four sizes. Thirty-two increments are enough to carry a start value across the signed and unsigned 32-bit and 64-bit boundaries, so wrap-around can be exercised within a single result. The four-element 64-bit case puts the last element, and so the C flag, only a few steps from the start value.

// File: rtl/whl_pkg.sv
package whl_pkg;

   localparam int OPW = 64;
   localparam int EXTW = OPW + 1;

   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } esz_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   // Widen a selected-width operand into a common signed compare space.
   function automatic logic [EXTW-1:0] extend_op(input logic [OPW-1:0] x,
                                                 input logic wide,
                                                 input logic uns);
      logic top;
      if (wide) begin
         top = uns ? 1'b0 : x[OPW-1];
         return {top, x};
      end
      top = uns ? 1'b0 : x[31];
      return {{(EXTW-32){top}}, x[31:0]};
   endfunction

endpackage

// File: rtl/whl_elem_cmp.sv
module whl_elem_cmp
   import whl_pkg::*;
#(
   parameter int unsigned OFFSET = 0
) (
   input  logic [OPW-1:0]  a_in,
   input  logic [EXTW-1:0] b_ext,
   input  logic            wide,
   input  logic            uns,
   input  logic            le,
   output logic            pass
);

   logic [OPW-1:0]  sum;
   logic [OPW-1:0]  val;
   logic [EXTW-1:0] a_ext;
   logic            lt;
   logic            eq;

   always_comb begin
      sum   = a_in + OPW'(OFFSET);
      val   = wide ? sum : {{(OPW-32){1'b0}}, sum[31:0]};
      a_ext = extend_op(val, wide, uns);
      lt    = $signed(a_ext) < $signed(b_ext);
      eq    = (a_ext == b_ext);
      pass  = lt | (le & eq);
   end

endmodule

// File: rtl/whl_pred_pack.sv
module whl_pred_pack
   import whl_pkg::*;
#(
   parameter int PL          = 32,
   parameter bit FAST_PREFIX = 1'b1
) (
   input  logic [PL-1:0] pass,
   input  esz_e          esz,
   output logic [PL-1:0] pred,
   output flags_t        flags
);

   localparam int LG = $clog2(PL);

   logic [PL-1:0] run;
   logic          last_run;

   generate
      if (FAST_PREFIX) begin : g_log_prefix
         logic [PL-1:0] lvl [LG+1];
         assign lvl[0] = pass;
         for (genvar k = 0; k < LG; k++) begin : g_lvl
            for (genvar i = 0; i < PL; i++) begin : g_pos
               if (i >= (1 << k)) begin : g_and
                  assign lvl[k+1][i] = lvl[k][i] & lvl[k][i-(1<<k)];
               end else begin : g_pass
                  assign lvl[k+1][i] = lvl[k][i];
               end
            end
         end
         assign run = lvl[LG];
      end else begin : g_ripple_prefix
         always_comb begin
            run[0] = pass[0];
            for (int i = 1; i < PL; i++) begin
               run[i] = run[i-1] & pass[i];
            end
         end
      end
   endgenerate

   generate
      for (genvar j = 0; j < PL; j++) begin : g_bit
         localparam bit LEAD16 = (j % 2) == 0;
         localparam bit LEAD32 = (j % 4) == 0;
         localparam bit LEAD64 = (j % 8) == 0;
         always_comb begin
            case (esz)
               ESZ_8:   pred[j] = run[j];
               ESZ_16:  pred[j] = LEAD16 ? run[j/2] : 1'b0;
               ESZ_32:  pred[j] = LEAD32 ? run[j/4] : 1'b0;
               default: pred[j] = LEAD64 ? run[j/8] : 1'b0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (esz)
         ESZ_8:   last_run = run[PL-1];
         ESZ_16:  last_run = run[PL/2-1];
         ESZ_32:  last_run = run[PL/4-1];
         default: last_run = run[PL/8-1];
      endcase
      flags.n = run[0];
      flags.z = ~|pred;
      flags.c = ~last_run;
      flags.v = 1'b0;
   end

endmodule

// File: rtl/whl_pred_gen.sv
module whl_pred_gen
   import whl_pkg::*;
#(
   parameter int VL_BITS     = 256,
   parameter bit FAST_PREFIX = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [63:0]          op_a,
   input  logic [63:0]          op_b,
   input  logic [1:0]           esize_sel,
   input  logic                 wide_sel,
   input  logic                 le_sel,
   input  logic                 unsigned_sel,
   output logic                 out_valid,
   output logic [VL_BITS/8-1:0] pred,
   output logic                 flag_n,
   output logic                 flag_z,
   output logic                 flag_c,
   output logic                 flag_v
);

   localparam int PL = VL_BITS / 8;

   generate
      if ((VL_BITS % 128) != 0) begin : g_bad_multiple
         $error("VL_BITS must be a multiple of 128");
      end
      if (VL_BITS < 128 || VL_BITS > 2048) begin : g_bad_range
         $error("VL_BITS must lie between 128 and 2048");
      end
   endgenerate

   logic [EXTW-1:0] b_ext;
   logic [PL-1:0]   pass;
   logic [PL-1:0]   pred_c;
   flags_t          flags_c;

   assign b_ext = extend_op(op_b, wide_sel, unsigned_sel);

   generate
      for (genvar e = 0; e < PL; e++) begin : g_elem
         whl_elem_cmp #(.OFFSET(e)) u_cmp (
            .a_in  (op_a),
            .b_ext (b_ext),
            .wide  (wide_sel),
            .uns   (unsigned_sel),
            .le    (le_sel),
            .pass  (pass[e])
         );
      end
   endgenerate

   whl_pred_pack #(.PL(PL), .FAST_PREFIX(FAST_PREFIX)) u_pack (
      .pass  (pass),
      .esz   (esz_e'(esize_sel)),
      .pred  (pred_c),
      .flags (flags_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pred      <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
         flag_v    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pred   <= pred_c;
            flag_n <= flags_c.n;
            flag_z <= flags_c.z;
            flag_c <= flags_c.c;
            flag_v <= flags_c.v;
         end
      end
   end

endmodule

// File: rtl/whl_pred_chk.sv
module whl_pred_chk #(
   parameter int PL = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    esize_sel,
   input logic          out_valid,
   input logic [PL-1:0] pred,
   input logic          flag_n,
   input logic          flag_z,
   input logic          flag_v
);

   logic [PL-1:0] lead_mask;

   always_comb begin
      for (int j = 0; j < PL; j++) begin
         lead_mask[j] = (j % (1 << esize_sel)) == 0;
      end
   end

   // R1: bits that are not the lowest bit of an element stay clear
   a_r1_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((pred & ~$past(lead_mask)) == '0));

   // R6: N follows the lowest predicate bit
   a_r6_n_first: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flag_n == pred[0]));

   // R7: Z set exactly when the predicate is empty
   a_r7_z_none: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flag_z == (pred == '0)));

   // R9: V never set
   a_r9_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_v);

   // R10: one-cycle latency for the valid strobe
   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10: no strobe, no valid and no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(pred)));

endmodule

bind whl_pred_gen whl_pred_chk #(.PL(PL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .esize_sel (esize_sel),
   .out_valid (out_valid),
   .pred      (pred),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_v    (flag_v)
);

// File: tb/sim_whl_pred_gen.sv
`timescale 1ns/1ps
module sim_whl_pred_gen;

   localparam int VL = 256;
   localparam int PL = VL / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [63:0]   op_a = '0;
   logic [63:0]   op_b = '0;
   logic [1:0]    esize_sel = '0;
   logic          wide_sel = 1'b0;
   logic          le_sel = 1'b0;
   logic          unsigned_sel = 1'b0;
   logic          out_valid;
   logic [PL-1:0] pred;
   logic          flag_n, flag_z, flag_c, flag_v;

   int n_checks = 0;
   int n_fail = 0;
   bit started = 1'b0;

   logic [PL-1:0] exp_pred = '0;
   logic          exp_valid = 1'b0;
   logic          exp_n = 1'b0, exp_z = 1'b0, exp_c = 1'b0;

   always #10 clk = ~clk;

   whl_pred_gen #(.VL_BITS(VL)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .esize_sel(esize_sel),
      .wide_sel(wide_sel), .le_sel(le_sel), .unsigned_sel(unsigned_sel),
      .out_valid(out_valid), .pred(pred),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Serial loop model written from the requirements.
   task automatic model(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic w,
                        input logic le, input logic u,
                        output logic [PL-1:0] p, output logic n,
                        output logic z, output logic c);
      int bytes_per = 1 << sz;
      int nel = PL / bytes_per;
      logic [63:0] cur;
      logic [64:0] xa, xb;
      bit alive = 1'b1;
      bit cond;
      p = '0;
      n = 1'b0;
      c = 1'b1;
      cur = w ? a : {32'h0, a[31:0]};
      if (w) xb = {(u ? 1'b0 : b[63]), b};
      else   xb = {{33{u ? 1'b0 : b[31]}}, b[31:0]};
      for (int e = 0; e < nel; e++) begin
         if (w) xa = {(u ? 1'b0 : cur[63]), cur};
         else   xa = {{33{u ? 1'b0 : cur[31]}}, cur[31:0]};
         cond = le ? ($signed(xa) <= $signed(xb)) : ($signed(xa) < $signed(xb));
         alive = alive && cond;
         p[e*bytes_per] = alive;
         if (e == 0) n = alive;
         if (e == nel - 1) c = !alive;
         if (w) cur = cur + 64'd1;
         else   cur = {32'h0, cur[31:0] + 32'd1};
      end
      z = (p == '0);
   endtask

   always @(posedge clk) begin
      logic [PL-1:0] mp;
      logic mn, mz, mc;
      if (!rst_n) begin
         exp_valid <= 1'b0;
         exp_pred  <= '0;
         exp_n <= 1'b0; exp_z <= 1'b0; exp_c <= 1'b0;
      end else begin
         started   <= 1'b1;
         exp_valid <= in_valid;
         if (in_valid) begin
            model(op_a, op_b, esize_sel, wide_sel, le_sel, unsigned_sel, mp, mn, mz, mc);
            exp_pred <= mp;
            exp_n <= mn; exp_z <= mz; exp_c <= mc;
         end
      end
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (started && rst_n) begin
         chk(pred == exp_pred, "R5", "pred vs model", 64'(pred), 64'(exp_pred));
         chk(flag_n == exp_n, "R6", "flag_n vs model", 64'(flag_n), 64'(exp_n));
         chk(flag_z == exp_z, "R7", "flag_z vs model", 64'(flag_z), 64'(exp_z));
         chk(flag_c == exp_c, "R8", "flag_c vs model", 64'(flag_c), 64'(exp_c));
         chk(flag_v == 1'b0, "R9", "flag_v", 64'(flag_v), 64'd0);
         chk(out_valid == exp_valid, "R10", "out_valid", 64'(out_valid), 64'(exp_valid));
      end
   end

   task automatic drive(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic w,
                        input logic le, input logic u);
      @(negedge clk);
      op_a = a; op_b = b; esize_sel = sz; wide_sel = w;
      le_sel = le; unsigned_sel = u; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic directed(input string req, input logic [63:0] a,
                           input logic [63:0] b, input logic [1:0] sz,
                           input logic w, input logic le, input logic u,
                           input logic [PL-1:0] ep, input logic en,
                           input logic ez, input logic ec);
      logic [PL-1:0] held;
      drive(a, b, sz, w, le, u);
      chk(pred == ep, req, "directed pred", 64'(pred), 64'(ep));
      chk({flag_n, flag_z, flag_c} == {en, ez, ec}, req, "directed NZC",
          64'({flag_n, flag_z, flag_c}), 64'({en, ez, ec}));
      held = pred;
      @(negedge clk);
      chk(pred == held && !out_valid, "R10", "hold between strobes",
          64'(pred), 64'(held));
   endtask

   function automatic logic [63:0] pick(input int sel);
      case (sel % 8)
         0: return {$urandom, $urandom};
         1: return 64'h0000_0000_7FFF_FFF0 + 64'($urandom % 32);
         2: return 64'h0000_0000_FFFF_FFF0 + 64'($urandom % 32);
         3: return 64'h7FFF_FFFF_FFFF_FFF0 + 64'($urandom % 32);
         4: return 64'hFFFF_FFFF_FFFF_FFF0 + 64'($urandom % 32);
         5: return 64'($urandom % 40) - 64'd20;
         6: return {$urandom, 32'h8000_0000 - 32'($urandom % 8)};
         default: return 64'($urandom % 64);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk({out_valid, pred, flag_n, flag_z, flag_c, flag_v} == '0, "R11",
          "reset outputs", 64'(pred), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: element sizes and packing
      directed("R1", 64'd0, 64'd3, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0015, 1'b1, 1'b0, 1'b1);
      directed("R1", 64'd0, 64'd2, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_0101, 1'b1, 1'b0, 1'b1);
      directed("R1", 64'd0, 64'd100, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1111_1111, 1'b1, 1'b0, 1'b0);
      directed("R1", 64'd0, 64'd100, 2'd0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
      // R2: upper halves ignored at 32-bit width
      directed("R2", 64'h1_0000_0000, 64'd5, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_001F, 1'b1, 1'b0, 1'b1);
      directed("R2", 64'h1_0000_0000, 64'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
      directed("R2", 64'd0, 64'hFFFF_FFFF_0000_0003, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0007, 1'b1, 1'b0, 1'b1);
      // R3: step of one per element even for 64-bit elements
      directed("R3", 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0101_0101, 1'b1, 1'b0, 1'b0);
      directed("R8", 64'd0, 64'd3, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0001_0101, 1'b1, 1'b0, 1'b1);
      // R4: unsigned and less-or-equal
      directed("R4", 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 2'd3, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b1);
      directed("R4", 64'd0, 64'd2, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0007, 1'b1, 1'b0, 1'b1);
      // R5: wrapped values do not re-enable elements
      directed("R5", 64'hFFFF_FFFE, 64'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b1);
      directed("R5", 64'h7FFF_FFFE, 64'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 1'b0, 1'b1);
      directed("R5", 64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 1'b0, 1'b1);
      // R6 and R7: first element fails
      directed("R7", 64'd5, 64'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

      // Mixed stimulus against the model, back-to-back and spaced
      for (int i = 0; i < 600; i++) begin
         logic [63:0] a, b;
         a = pick(int'($urandom));
         b = ($urandom % 2 == 1) ? a + 64'($urandom % 48) - 64'd4 : pick(int'($urandom));
         @(negedge clk);
         op_a = a; op_b = b;
         esize_sel = 2'($urandom); wide_sel = 1'($urandom);
         le_sel = 1'($urandom); unsigned_sel = 1'($urandom);
         in_valid = ($urandom % 4) != 0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule